// File: doc/BRIEF.md
# User-Mode Address Range Guard

This block sits beside the processor's memory port and decides, for each address the processor issues, whether the access is allowed. Two range registers define one legal window. The first register is the lowest permitted address. The second is the number of permitted addresses, counted from that lowest address. The check applies only while the processor runs in user mode. In monitor mode every access is allowed with no check. The block compares addresses only and never changes them.

The range registers are loaded through a small write port. A write is honoured only when the processor is in monitor mode, which is the privileged state. A write tried from user mode changes nothing and raises a protection fault.

For a user-mode access outside the window, the grant output drops in the same cycle the address is presented. A one-cycle fault pulse follows on the next cycle. The offending address is captured and held for software until the next access fault replaces it.

Top module: `addr_guard`

## Requirements
- R1: After synchronous reset the lower bound and the window size are both 0, `fault` is 0 and `fault_addr` is 0. As a result, every user-mode access is refused until the registers are loaded.
- R2: While `user_mode` is 0 (monitor), every access with `req_valid` high is granted in the same cycle, and it causes no fault.
- R3: While `user_mode` is 1, an access is granted in the same cycle exactly when lower <= addr < lower + size. The sum is formed one bit wider than the address.
- R4: A refused user-mode access drives `grant` low in the cycle it is presented. In the next cycle `fault` is high for one cycle and `fault_addr` holds the refused address.
- R5: A window size of 0 makes every user-mode address illegal.
- R6: When lower + size is larger than the address space, the window does not wrap. Addresses from lower to the top of the space are legal, and addresses below lower stay illegal.
- R7: A write with `cfg_we` high and `user_mode` 0 loads the lower bound when `cfg_sel` is 0, or the window size when `cfg_sel` is 1. The new value governs accesses from the next cycle on.
- R8: A write with `cfg_we` high and `user_mode` 1 leaves both registers unchanged and pulses `fault` in the next cycle. `fault_addr` keeps its previous value.
- R9: `fault_addr` changes only when a refused access is captured. Otherwise it keeps its value.
- R10: With `req_valid` low, `grant` is 0 and no access fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address valid strobe |
| req_addr | input | ADDR_W | Address issued by the processor |
| user_mode | input | 1 | Mode bit: 1 = user, 0 = monitor |
| cfg_we | input | 1 | Privileged register write strobe |
| cfg_sel | input | 1 | Write target: 0 = lower bound, 1 = window size |
| cfg_data | input | ADDR_W | Write data |
| grant | output | 1 | Access permitted, same cycle as the address |
| fault | output | 1 | One-cycle protection fault pulse |
| fault_addr | output | ADDR_W | Last refused address |

## Verification
The bench sweeps every address of a 6-bit space against several windows. These include an empty window, a window that reaches past the top of the space, and single-address windows at both ends. An off-by-one bound would show up at the edges of these windows as a wrongly granted or wrongly refused address. A sum kept at the address width would wrap to a small end value, which would refuse the top addresses and could grant the low ones. Range writes tried from user mode are followed by a full sweep, so that a register changed by such a write shows up as a changed window. A check that leaked into monitor mode would refuse accesses during the monitor-mode sweep. A fault address captured on config faults, or never captured, is caught by following the held value across several faults.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;
  typedef enum logic {
    SEL_LOWER = 1'b0,
    SEL_SIZE  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/addr_guard_regs.sv
module addr_guard_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              user_mode,
  output logic [ADDR_W-1:0] lower_q,
  output logic [ADDR_W-1:0] size_q,
  output logic              wr_denied
);
  import addr_guard_pkg::*;

  logic wr_ok;

  assign wr_ok     = cfg_we && !user_mode;
  assign wr_denied = cfg_we && user_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      lower_q <= '0;
      size_q  <= '0;
    end else if (wr_ok) begin
      if (cfg_sel_e'(cfg_sel) == SEL_LOWER) lower_q <= cfg_data;
      else                                  size_q  <= cfg_data;
    end
  end
endmodule

// File: rtl/addr_guard_cmp.sv
module addr_guard_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              user_mode,
  input  logic [ADDR_W-1:0] lower_q,
  input  logic [ADDR_W-1:0] size_q,
  output logic              grant,
  output logic              acc_denied
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] end_x;
  logic [EXT_W-1:0] addr_x;
  logic             in_range;

  always_comb begin
    end_x    = {1'b0, lower_q} + {1'b0, size_q};
    addr_x   = {1'b0, req_addr};
    in_range = (req_addr >= lower_q) && (addr_x < end_x);
  end

  assign grant      = req_valid && (!user_mode || in_range);
  assign acc_denied = req_valid && user_mode && !in_range;
endmodule

// File: rtl/addr_guard_fault.sv
module addr_guard_fault #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_denied,
  input  logic              wr_denied,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fault      <= 1'b0;
      fault_addr <= '0;
    end else begin
      fault <= acc_denied || wr_denied;
      if (acc_denied) fault_addr <= req_addr;
    end
  end
endmodule

// File: rtl/addr_guard.sv
module addr_guard #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              user_mode,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic              grant,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr
);
  logic [ADDR_W-1:0] lower_q;
  logic [ADDR_W-1:0] size_q;
  logic              wr_denied;
  logic              acc_denied;

  addr_guard_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .user_mode (user_mode),
    .lower_q   (lower_q),
    .size_q    (size_q),
    .wr_denied (wr_denied)
  );

  addr_guard_cmp #(.ADDR_W(ADDR_W)) cmp_i (
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .user_mode  (user_mode),
    .lower_q    (lower_q),
    .size_q     (size_q),
    .grant      (grant),
    .acc_denied (acc_denied)
  );

  addr_guard_fault #(.ADDR_W(ADDR_W)) fault_i (
    .clk        (clk),
    .rst        (rst),
    .acc_denied (acc_denied),
    .wr_denied  (wr_denied),
    .req_addr   (req_addr),
    .fault      (fault),
    .fault_addr (fault_addr)
  );
endmodule

// File: rtl/addr_guard_chk.sv
module addr_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              user_mode,
  input logic              cfg_we,
  input logic              grant,
  input logic              fault,
  input logic [ADDR_W-1:0] fault_addr
);
  assert_monitor_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !user_mode) |-> grant);

  assert_idle_no_grant_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !grant);

  assert_deny_captured_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && user_mode && !grant) |=> (fault && fault_addr == $past(req_addr)));

  assert_user_write_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && user_mode) |=> fault);

  assert_fault_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past((req_valid && user_mode && !grant) || (cfg_we && user_mode)));

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
    !fault |-> $stable(fault_addr));
endmodule

bind addr_guard addr_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .user_mode  (user_mode),
  .cfg_we     (cfg_we),
  .grant      (grant),
  .fault      (fault),
  .fault_addr (fault_addr)
);

// File: tb/addr_guard_tb_top.sv
`timescale 1ns/1ps
module addr_guard_tb_top;
  localparam int W    = 6;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [W-1:0] req_addr = '0;
  logic         user_mode = 1'b0;
  logic         cfg_we = 1'b0;
  logic         cfg_sel = 1'b0;
  logic [W-1:0] cfg_data = '0;
  logic         grant;
  logic         fault;
  logic [W-1:0] fault_addr;

  int errors = 0;
  int checks = 0;
  int m_lower = 0;
  int m_size = 0;
  int m_held = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_guard #(.ADDR_W(W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .user_mode(user_mode), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .grant(grant), .fault(fault), .fault_addr(fault_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one access; grant checked same cycle, fault/fault_addr one cycle later
  task automatic access(input int a, input bit usr, input string req);
    bit legal;
    bit deny;
    legal = (a >= m_lower) && (a < m_lower + m_size);
    deny  = usr && !legal;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = W'(a);
    user_mode = usr;
    #1;
    check(req, int'(grant), int'(!deny));
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (deny) m_held = a;
    check({req, " fault"}, int'(fault), int'(deny));
    check("R9 fault_addr", int'(fault_addr), m_held);
  endtask

  task automatic write_reg(input bit sel, input int d, input bit usr);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = sel;
    cfg_data  = W'(d);
    user_mode = usr;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (!usr) begin
      if (sel) m_size = d;
      else     m_lower = d;
    end
    check(usr ? "R8 write fault" : "R7 write no fault", int'(fault), int'(usr));
    check("R8 fault_addr kept", int'(fault_addr), m_held);
  endtask

  task automatic sweep(input bit usr, input string req);
    for (int a = 0; a < SPAN; a++) access(a, usr, req);
  endtask

  task automatic window(input int lo, input int sz, input string req);
    write_reg(1'b0, lo, 1'b0);
    write_reg(1'b1, sz, 1'b0);
    sweep(1'b1, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 fault reset", int'(fault), 0);
    check("R1 fault_addr reset", int'(fault_addr), 0);
    check("R10 idle grant", int'(grant), 0);
    // R1/R5: reset window is empty
    sweep(1'b1, "R1 R5 empty window");
    // R2: monitor mode ignores the window
    sweep(1'b0, "R2 monitor");
    // R3/R7: ordinary windows
    window(10, 20, "R3 window 10+20");
    window(0, 63, "R3 window 0+63");
    window(5, 1, "R3 single low");
    window(63, 1, "R3 single top");
    // R6: window reaching past the top
    window(60, 10, "R6 no wrap");
    window(1, 63, "R6 reaches top");
    // R8: user writes change nothing
    write_reg(1'b0, 0, 1'b1);
    write_reg(1'b1, 5, 1'b1);
    sweep(1'b1, "R8 window unchanged");
    // R5: explicit zero size
    window(30, 0, "R5 zero size");
    // R10: idle cycle, no fault
    @(negedge clk);
    req_valid = 1'b0;
    user_mode = 1'b1;
    req_addr  = W'(0);
    #1;
    check("R10 idle grant", int'(grant), 0);
    @(posedge clk);
    #1;
    check("R10 idle fault", int'(fault), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule